// File: doc/BRIEF.md
# UART Register and Interrupt Bank

This block is the software-visible front end of a UART. It decodes 32-bit word accesses from an APB-style bus onto a fixed map of registers: the data port, the receive status word, a flag word, the baud and low-power divisors, line and control settings, the FIFO level select, DMA control, and a set of interrupt registers. Writing the data port sends one transmit byte to the serial engine. Reading it removes the oldest entry from an internal receive queue, which the serial engine fills through a push port.

The block keeps an 11-bit raw interrupt vector. It sets the bits itself for transmit, receive and overrun, and it also takes set pulses from neighbouring line and modem logic. Software selects bits with a mask and clears them with a write-one-to-clear register. One combined interrupt line goes high when any unmasked raw bit is set. A read-only window of eight identification bytes sits in the last eight words of the 4 KB space.

Top module: `uart_regbank`

## Requirements
- R1: After reset, the control word (byte address 0x030) reads 0x300, the flag word (0x018) reads 0x90, the level select (0x034) reads 0x12, and the mask (0x038), raw status (0x03C) and receive status (0x004) words read 0.
- R2: The configuration words keep only their implemented low bits and read back zero-extended: low-power divisor 0x020 (8 bits), integer divisor 0x024 (16), fractional divisor 0x028 (6), line control 0x02C (8), control 0x030 (16), level select 0x034 (6), DMA control 0x048 (3).
- R3: The flag word has bit 7 transmit empty (always 1), bit 6 receive full (queue holds RXQ_DEPTH entries), bit 5 transmit full (always 0) and bit 4 receive empty (queue holds nothing). Writes to 0x018 change nothing.
- R4: A write to the data word 0x000 raises tx_valid_o for exactly one cycle after the access, with tx_byte_o equal to the low 8 bits of the written word, and sets raw bit 5.
- R5: A pulse on rx_push_i that the queue accepts stores {rx_err_i, rx_byte_i} and sets raw bit 4.
- R6: A read of 0x000 returns the oldest queued entry as {4 error bits in 11:8, byte in 7:0} and pops it. The error bits are copied into the receive status word 0x004. A read of an empty queue returns 0, pops nothing and leaves the status word unchanged. Raw bit 4 is cleared when a pop empties the queue.
- R7: A push into a full queue with no pop in the same cycle is dropped, and it sets raw bit 10 (overrun).
- R8: Any write to 0x004 clears the receive status word.
- R9: A 1 in bit b of evt_i sets raw bit b. The raw bits are 10 overrun, 9 break, 8 parity, 7 framing, 6 receive timeout, 5 transmit, 4 receive, 3 DSR, 2 DCD, 1 CTS, 0 ring.
- R10: The mask 0x038 and raw status 0x03C keep 11 bits and read back zero-extended. The masked status 0x040 reads raw AND mask.
- R11: A write to the clear word 0x044 clears each raw bit written as 1. A set arriving in the same cycle wins.
- R12: irq_o is high exactly when raw AND mask is nonzero.
- R13: Reads of 0xFE0 through 0xFFC return 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, one byte per word in address order.
- R14: Reads of unmapped words (for example 0x01C, 0x0FC, 0xFDC) and of the write-only clear word return 0. Writes to unmapped words, to the raw status word and to the masked status word change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| tx_valid_o | output | 1 | Transmit byte strobe |
| tx_byte_o | output | 8 | Transmit byte |
| rx_push_i | input | 1 | Receive entry push |
| rx_byte_i | input | 8 | Received byte |
| rx_err_i | input | 4 | Error bits for the received byte |
| evt_i | input | 11 | Raw interrupt set pulses |
| irq_o | output | 1 | Combined interrupt |

## Verification
A wrong queue pointer or count shows up on the next data read as a misordered entry, and as a wrong empty or full flag on the next flag read. A raw bit stuck set, or lost, shows on irq_o in the cycle after the access that should have changed it, provided the bit is unmasked. Otherwise it shows only when the raw or masked status word is read. A bad decode returns a wrong value on the first read of the affected word. Filling the queue past its depth and then draining it shows ordering, full detection and overrun together.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

   localparam int IRQ_W  = 11;
   localparam int ERR_W  = 4;
   localparam int BYTE_W = 8;

   // Raw interrupt bit positions that this bank drives itself
   localparam int IRQ_RX  = 4;
   localparam int IRQ_TX  = 5;
   localparam int IRQ_OVR = 10;

   // Flag word bit positions
   localparam int FLG_RXE = 4;
   localparam int FLG_TXF = 5;
   localparam int FLG_RXF = 6;
   localparam int FLG_TXE = 7;

   // Word indexes (byte address >> 2)
   localparam int W_DATA  = 0;
   localparam int W_RSTS  = 1;
   localparam int W_FLAG  = 6;
   localparam int W_LPDIV = 8;
   localparam int W_IBAUD = 9;
   localparam int W_FBAUD = 10;
   localparam int W_LINE  = 11;
   localparam int W_CTRL  = 12;
   localparam int W_LVL   = 13;
   localparam int W_MASK  = 14;
   localparam int W_RAW   = 15;
   localparam int W_MSTS  = 16;
   localparam int W_CLR   = 17;
   localparam int W_DMA   = 18;
   localparam int W_ID_LO = 'h3F8;
   localparam int W_ID_HI = 'h3FF;

   // Implemented widths of configuration words
   localparam int LPDIV_W = 8;
   localparam int IBAUD_W = 16;
   localparam int FBAUD_W = 6;
   localparam int LINE_W  = 8;
   localparam int CTRL_W  = 16;
   localparam int LVL_W   = 6;
   localparam int DMA_W   = 3;

   localparam logic [CTRL_W-1:0] CTRL_RST = 16'h0300;
   localparam logic [LVL_W-1:0]  LVL_RST  = 6'h12;

   typedef struct packed {
      logic [ERR_W-1:0]  err;
      logic [BYTE_W-1:0] data;
   } rx_entry_t;

   function automatic logic [7:0] id_byte(input logic [2:0] idx);
      case (idx)
         3'd0: id_byte = 8'h11;
         3'd1: id_byte = 8'h10;
         3'd2: id_byte = 8'h14;
         3'd3: id_byte = 8'h00;
         3'd4: id_byte = 8'h0D;
         3'd5: id_byte = 8'hF0;
         3'd6: id_byte = 8'h05;
         default: id_byte = 8'hB1;
      endcase
   endfunction

endpackage

// File: rtl/uart_regbank_field.sv
module uart_regbank_field #(
   parameter int          W   = 8,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("uart_regbank_field: W must be positive");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  q <= RST;
      else if (we) q <= d;
   end
endmodule

// File: rtl/uart_regbank_rxq.sv
module uart_regbank_rxq
   import uart_regbank_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      push,
   input  rx_entry_t din,
   input  logic      pop,
   output rx_entry_t dout,
   output logic      empty,
   output logic      full,
   output logic      last,
   output logic      accept
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = PTR_W + 1;

   if (DEPTH < 2 || (1 << PTR_W) != DEPTH) begin : g_bad_depth
      $error("uart_regbank_rxq: DEPTH must be a power of two, at least 2");
   end

   rx_entry_t        mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] count;
   logic             do_pop;

   assign empty  = (count == '0);
   assign full   = (count == CNT_W'(DEPTH));
   assign last   = (count == CNT_W'(1));
   assign do_pop = pop && !empty;
   assign accept = push && (!full || do_pop);
   assign dout   = mem[rd_ptr];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (accept && wr_ptr == PTR_W'(i)) mem[i] <= din;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (accept) wr_ptr <= wr_ptr + PTR_W'(1);
         if (do_pop) rd_ptr <= rd_ptr + PTR_W'(1);
         case ({accept, do_pop})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/uart_regbank_irq.sv
module uart_regbank_irq #(
   parameter int W = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   input  logic         mask_we,
   input  logic [W-1:0] mask_d,
   output logic [W-1:0] raw_o,
   output logic [W-1:0] mask_o,
   output logic         irq_o
);
   if (W < 1 || W > 32) begin : g_bad_w
      $error("uart_regbank_irq: W must be within 1..32");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)          raw_o[b] <= 1'b0;
         else if (set_i[b])   raw_o[b] <= 1'b1;
         else if (clr_i[b])   raw_o[b] <= 1'b0;
      end
      always_ff @(posedge clk) begin
         if (!rst_n)       mask_o[b] <= 1'b0;
         else if (mask_we) mask_o[b] <= mask_d[b];
      end
   end

   assign irq_o = |(raw_o & mask_o);
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
   import uart_regbank_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int RXQ_DEPTH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [31:0]       pwdata,
   output logic [31:0]       prdata,
   output logic              tx_valid_o,
   output logic [7:0]        tx_byte_o,
   input  logic              rx_push_i,
   input  logic [7:0]        rx_byte_i,
   input  logic [3:0]        rx_err_i,
   input  logic [10:0]       evt_i,
   output logic              irq_o
);
   localparam int WORD_W = ADDR_W - 2;

   if (ADDR_W < 12) begin : g_bad_addr
      $error("uart_regbank: ADDR_W must cover a 4 KB window");
   end

   logic [WORD_W-1:0] word;
   logic acc, wr, rd;
   assign word = paddr[ADDR_W-1:2];
   assign acc  = psel && penable;
   assign wr   = acc && pwrite;
   assign rd   = acc && !pwrite;

   logic s_data, s_rsts, s_flag, s_lpdiv, s_ibaud, s_fbaud, s_line;
   logic s_ctrl, s_lvl, s_mask, s_raw, s_msts, s_clr, s_dma, s_id;
   assign s_data  = (word == WORD_W'(W_DATA));
   assign s_rsts  = (word == WORD_W'(W_RSTS));
   assign s_flag  = (word == WORD_W'(W_FLAG));
   assign s_lpdiv = (word == WORD_W'(W_LPDIV));
   assign s_ibaud = (word == WORD_W'(W_IBAUD));
   assign s_fbaud = (word == WORD_W'(W_FBAUD));
   assign s_line  = (word == WORD_W'(W_LINE));
   assign s_ctrl  = (word == WORD_W'(W_CTRL));
   assign s_lvl   = (word == WORD_W'(W_LVL));
   assign s_mask  = (word == WORD_W'(W_MASK));
   assign s_raw   = (word == WORD_W'(W_RAW));
   assign s_msts  = (word == WORD_W'(W_MSTS));
   assign s_clr   = (word == WORD_W'(W_CLR));
   assign s_dma   = (word == WORD_W'(W_DMA));
   assign s_id    = (word >= WORD_W'(W_ID_LO)) && (word <= WORD_W'(W_ID_HI));

   // Configuration words
   logic [LPDIV_W-1:0] lpdiv_q;
   logic [IBAUD_W-1:0] ibaud_q;
   logic [FBAUD_W-1:0] fbaud_q;
   logic [LINE_W-1:0]  line_q;
   logic [CTRL_W-1:0]  ctrl_q;
   logic [LVL_W-1:0]   lvl_q;
   logic [DMA_W-1:0]   dma_q;

   uart_regbank_field #(.W(LPDIV_W)) u_lpdiv (.clk(clk), .rst_n(rst_n),
      .we(wr && s_lpdiv), .d(pwdata[LPDIV_W-1:0]), .q(lpdiv_q));
   uart_regbank_field #(.W(IBAUD_W)) u_ibaud (.clk(clk), .rst_n(rst_n),
      .we(wr && s_ibaud), .d(pwdata[IBAUD_W-1:0]), .q(ibaud_q));
   uart_regbank_field #(.W(FBAUD_W)) u_fbaud (.clk(clk), .rst_n(rst_n),
      .we(wr && s_fbaud), .d(pwdata[FBAUD_W-1:0]), .q(fbaud_q));
   uart_regbank_field #(.W(LINE_W)) u_line (.clk(clk), .rst_n(rst_n),
      .we(wr && s_line), .d(pwdata[LINE_W-1:0]), .q(line_q));
   uart_regbank_field #(.W(CTRL_W), .RST(CTRL_RST)) u_ctrl (.clk(clk), .rst_n(rst_n),
      .we(wr && s_ctrl), .d(pwdata[CTRL_W-1:0]), .q(ctrl_q));
   uart_regbank_field #(.W(LVL_W), .RST(LVL_RST)) u_lvl (.clk(clk), .rst_n(rst_n),
      .we(wr && s_lvl), .d(pwdata[LVL_W-1:0]), .q(lvl_q));
   uart_regbank_field #(.W(DMA_W)) u_dma (.clk(clk), .rst_n(rst_n),
      .we(wr && s_dma), .d(pwdata[DMA_W-1:0]), .q(dma_q));

   // Receive queue
   rx_entry_t rx_in, rx_head;
   logic      rx_empty, rx_full, rx_last, rx_accept, rx_pop;
   assign rx_in  = '{err: rx_err_i, data: rx_byte_i};
   assign rx_pop = rd && s_data && !rx_empty;

   uart_regbank_rxq #(.DEPTH(RXQ_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .push(rx_push_i), .din(rx_in), .pop(rx_pop), .dout(rx_head),
      .empty(rx_empty), .full(rx_full), .last(rx_last), .accept(rx_accept));

   // Receive status word
   logic [ERR_W-1:0] rsr_q;
   always_ff @(posedge clk) begin
      if (!rst_n)              rsr_q <= '0;
      else if (wr && s_rsts)   rsr_q <= '0;
      else if (rx_pop)         rsr_q <= rx_head.err;
   end

   // Transmit strobe
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_valid_o <= 1'b0;
         tx_byte_o  <= '0;
      end else begin
         tx_valid_o <= wr && s_data;
         if (wr && s_data) tx_byte_o <= pwdata[7:0];
      end
   end

   // Interrupts
   logic [IRQ_W-1:0] irq_set, irq_clr, raw_q, mask_q;
   always_comb begin
      irq_set          = evt_i;
      irq_set[IRQ_TX]  = evt_i[IRQ_TX]  | (wr && s_data);
      irq_set[IRQ_RX]  = evt_i[IRQ_RX]  | rx_accept;
      irq_set[IRQ_OVR] = evt_i[IRQ_OVR] | (rx_push_i && !rx_accept);
      irq_clr          = (wr && s_clr) ? pwdata[IRQ_W-1:0] : '0;
      irq_clr[IRQ_RX]  = irq_clr[IRQ_RX] | (rx_pop && rx_last);
   end

   uart_regbank_irq #(.W(IRQ_W)) u_irq (
      .clk(clk), .rst_n(rst_n), .set_i(irq_set), .clr_i(irq_clr),
      .mask_we(wr && s_mask), .mask_d(pwdata[IRQ_W-1:0]),
      .raw_o(raw_q), .mask_o(mask_q), .irq_o(irq_o));

   // Read mux
   logic [7:0] flags;
   always_comb begin
      flags          = '0;
      flags[FLG_TXE] = 1'b1;
      flags[FLG_TXF] = 1'b0;
      flags[FLG_RXF] = rx_full;
      flags[FLG_RXE] = rx_empty;
   end

   always_comb begin
      prdata = '0;
      if (rd) begin
         if (s_data && !rx_empty) prdata = 32'(rx_head);
         else if (s_rsts)  prdata = 32'(rsr_q);
         else if (s_flag)  prdata = 32'(flags);
         else if (s_lpdiv) prdata = 32'(lpdiv_q);
         else if (s_ibaud) prdata = 32'(ibaud_q);
         else if (s_fbaud) prdata = 32'(fbaud_q);
         else if (s_line)  prdata = 32'(line_q);
         else if (s_ctrl)  prdata = 32'(ctrl_q);
         else if (s_lvl)   prdata = 32'(lvl_q);
         else if (s_mask)  prdata = 32'(mask_q);
         else if (s_raw)   prdata = 32'(raw_q);
         else if (s_msts)  prdata = 32'(raw_q & mask_q);
         else if (s_dma)   prdata = 32'(dma_q);
         else if (s_id)    prdata = 32'(id_byte(word[2:0]));
      end
   end
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk #(
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              psel,
   input logic              penable,
   input logic              pwrite,
   input logic [ADDR_W-1:0] paddr,
   input logic [31:0]       pwdata,
   input logic              rx_push_i,
   input logic [10:0]       evt_i,
   input logic              tx_valid_o,
   input logic              irq_o,
   input logic [10:0]       raw_q,
   input logic [10:0]       mask_q,
   input logic              rx_empty,
   input logic              rx_full,
   input logic [3:0]        rsr_q
);
   logic [ADDR_W-3:0] word;
   logic wr_any, wr_data, wr_clr, wr_rsts;
   assign word    = paddr[ADDR_W-1:2];
   assign wr_any  = psel && penable && pwrite;
   assign wr_data = wr_any && (word == '0);
   assign wr_rsts = wr_any && (word == (ADDR_W-2)'(1));
   assign wr_clr  = wr_any && (word == (ADDR_W-2)'(17));

   // R4
   tx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data |=> tx_valid_o && raw_q[5]);

   // R4
   tx_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid_o |-> $past(wr_data));

   // R11
   w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr && evt_i == '0 && !rx_push_i) |=> ((raw_q & $past(pwdata[10:0])) == '0));

   // R3
   flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_empty && rx_full));

   // R12
   irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq_o);

   // R8
   rsts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_rsts |=> (rsr_q == '0));
endmodule

bind uart_regbank uart_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
   .paddr(paddr), .pwdata(pwdata), .rx_push_i(rx_push_i), .evt_i(evt_i),
   .tx_valid_o(tx_valid_o), .irq_o(irq_o), .raw_q(raw_q), .mask_q(mask_q),
   .rx_empty(rx_empty), .rx_full(rx_full), .rsr_q(rsr_q));

// File: tb/uart_regbank_tb.sv
module uart_regbank_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        tx_valid_o;
   logic [7:0]  tx_byte_o;
   logic        rx_push_i = 1'b0;
   logic [7:0]  rx_byte_i = '0;
   logic [3:0]  rx_err_i = '0;
   logic [10:0] evt_i = '0;
   logic        irq_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   uart_regbank u_dut (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .tx_valid_o(tx_valid_o), .tx_byte_o(tx_byte_o),
      .rx_push_i(rx_push_i), .rx_byte_i(rx_byte_i), .rx_err_i(rx_err_i),
      .evt_i(evt_i), .irq_o(irq_o));

   typedef struct packed {
      logic        wr;
      logic [3:0]  req;
      logic [11:0] addr;
      logic [31:0] data;
      logic [31:0] exp;
   } vec_t;

   localparam int NV = 42;
   localparam vec_t VEC [NV] = '{
      // R1 reset values
      '{1'b0, 4'd1, 12'h030, 32'h0, 32'h300},
      '{1'b0, 4'd1, 12'h018, 32'h0, 32'h90},
      '{1'b0, 4'd1, 12'h034, 32'h0, 32'h12},
      '{1'b0, 4'd1, 12'h038, 32'h0, 32'h0},
      '{1'b0, 4'd1, 12'h03C, 32'h0, 32'h0},
      '{1'b0, 4'd1, 12'h004, 32'h0, 32'h0},
      // R2 configuration widths
      '{1'b1, 4'd2, 12'h020, 32'hFFFFFFAB, 32'h0},
      '{1'b0, 4'd2, 12'h020, 32'h0, 32'hAB},
      '{1'b1, 4'd2, 12'h024, 32'h12345678, 32'h0},
      '{1'b0, 4'd2, 12'h024, 32'h0, 32'h5678},
      '{1'b1, 4'd2, 12'h028, 32'hFF, 32'h0},
      '{1'b0, 4'd2, 12'h028, 32'h0, 32'h3F},
      '{1'b1, 4'd2, 12'h02C, 32'h1F0, 32'h0},
      '{1'b0, 4'd2, 12'h02C, 32'h0, 32'hF0},
      '{1'b1, 4'd2, 12'h030, 32'hABCD1234, 32'h0},
      '{1'b0, 4'd2, 12'h030, 32'h0, 32'h1234},
      '{1'b1, 4'd2, 12'h034, 32'hFF, 32'h0},
      '{1'b0, 4'd2, 12'h034, 32'h0, 32'h3F},
      '{1'b1, 4'd2, 12'h048, 32'hF, 32'h0},
      '{1'b0, 4'd2, 12'h048, 32'h0, 32'h7},
      // R3 flag writes ignored
      '{1'b1, 4'd3, 12'h018, 32'h0, 32'h0},
      '{1'b0, 4'd3, 12'h018, 32'h0, 32'h90},
      // R14 unmapped and read-only words
      '{1'b1, 4'd14, 12'h01C, 32'hFFFFFFFF, 32'h0},
      '{1'b0, 4'd14, 12'h01C, 32'h0, 32'h0},
      '{1'b0, 4'd14, 12'h044, 32'h0, 32'h0},
      '{1'b0, 4'd14, 12'h0FC, 32'h0, 32'h0},
      '{1'b1, 4'd14, 12'h03C, 32'h7FF, 32'h0},
      '{1'b0, 4'd14, 12'h03C, 32'h0, 32'h0},
      '{1'b1, 4'd14, 12'h040, 32'h7FF, 32'h0},
      '{1'b0, 4'd14, 12'h040, 32'h0, 32'h0},
      '{1'b0, 4'd14, 12'hFDC, 32'h0, 32'h0},
      // R13 identification window
      '{1'b0, 4'd13, 12'hFE0, 32'h0, 32'h11},
      '{1'b0, 4'd13, 12'hFE4, 32'h0, 32'h10},
      '{1'b0, 4'd13, 12'hFE8, 32'h0, 32'h14},
      '{1'b0, 4'd13, 12'hFEC, 32'h0, 32'h00},
      '{1'b0, 4'd13, 12'hFF0, 32'h0, 32'h0D},
      '{1'b0, 4'd13, 12'hFF4, 32'h0, 32'hF0},
      '{1'b0, 4'd13, 12'hFF8, 32'h0, 32'h05},
      '{1'b0, 4'd13, 12'hFFC, 32'h0, 32'hB1},
      // R10 mask width
      '{1'b1, 4'd10, 12'h038, 32'hFFFFFFFF, 32'h0},
      '{1'b0, 4'd10, 12'h038, 32'h0, 32'h7FF},
      '{1'b1, 4'd10, 12'h038, 32'h0, 32'h0}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
      @(negedge clk);
      penable = 1'b1;
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic apb_wr_evt(input logic [11:0] a, input logic [31:0] d, input logic [10:0] ev);
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
      @(negedge clk);
      penable = 1'b1; evt_i = ev;
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0; evt_i = '0;
   endtask

   task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b0; paddr = a;
      @(negedge clk);
      penable = 1'b1;
      #1 d = prdata;
      @(negedge clk);
      psel = 1'b0; penable = 1'b0;
   endtask

   task automatic rx_push(input logic [7:0] b, input logic [3:0] e);
      @(negedge clk);
      rx_push_i = 1'b1; rx_byte_i = b; rx_err_i = e;
      @(negedge clk);
      rx_push_i = 1'b0;
   endtask

   task automatic evt_pulse(input logic [10:0] ev);
      @(negedge clk);
      evt_i = ev;
      @(negedge clk);
      evt_i = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not complete");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // Table walk: R1, R2, R3, R10, R13, R14
      for (int i = 0; i < NV; i++) begin
         if (VEC[i].wr) apb_wr(VEC[i].addr, VEC[i].data);
         else begin
            apb_rd(VEC[i].addr, r);
            check($sformatf("R%0d table row %0d", VEC[i].req, i), r, VEC[i].exp);
         end
      end

      // R4 transmit strobe and raw bit 5
      apb_wr(12'h000, 32'h123456C3);
      check("R4 tx_valid pulse", 32'(tx_valid_o), 32'h1);
      check("R4 tx_byte", 32'(tx_byte_o), 32'hC3);
      @(negedge clk);
      check("R4 tx_valid single cycle", 32'(tx_valid_o), 32'h0);
      apb_rd(12'h03C, r);
      check("R4 raw tx bit", r, 32'h20);

      // R10 R12 masked status and combined line
      apb_wr(12'h038, 32'h20);
      apb_rd(12'h040, r);
      check("R10 masked status", r, 32'h20);
      check("R12 irq high", 32'(irq_o), 32'h1);
      // R11 clear
      apb_wr(12'h044, 32'h20);
      apb_rd(12'h03C, r);
      check("R11 raw after clear", r, 32'h0);
      check("R12 irq low after clear", 32'(irq_o), 32'h0);

      // R5 R6 receive path
      rx_push(8'h41, 4'h0);
      rx_push(8'hA5, 4'h3);
      apb_rd(12'h018, r);
      check("R3 flags with two entries", r, 32'h80);
      apb_rd(12'h03C, r);
      check("R5 raw rx bit", r, 32'h10);
      apb_rd(12'h000, r);
      check("R6 first entry", r, 32'h041);
      apb_rd(12'h004, r);
      check("R6 status after clean byte", r, 32'h0);
      apb_rd(12'h000, r);
      check("R6 second entry", r, 32'h3A5);
      apb_rd(12'h004, r);
      check("R6 status error bits", r, 32'h3);
      apb_rd(12'h03C, r);
      check("R6 rx bit cleared on empty", r, 32'h0);
      apb_rd(12'h018, r);
      check("R3 flags empty again", r, 32'h90);
      apb_rd(12'h000, r);
      check("R6 empty read returns zero", r, 32'h0);
      apb_rd(12'h004, r);
      check("R6 empty read keeps status", r, 32'h3);
      // R8
      apb_wr(12'h004, 32'h0);
      apb_rd(12'h004, r);
      check("R8 status cleared", r, 32'h0);

      // R7 fill, overrun, drain
      for (int i = 0; i < 16; i++) rx_push(8'(8'h10 + i), 4'h0);
      apb_rd(12'h018, r);
      check("R3 flags full", r, 32'hC0);
      rx_push(8'hEE, 4'hF);
      apb_rd(12'h03C, r);
      check("R7 overrun bit", r, 32'h410);
      for (int i = 0; i < 16; i++) begin
         apb_rd(12'h000, r);
         check($sformatf("R7 drain entry %0d", i), r, 32'(8'h10 + i));
      end
      apb_rd(12'h018, r);
      check("R7 dropped byte absent", r, 32'h90);

      // R9 event inputs
      apb_wr(12'h044, 32'h7FF);
      apb_wr(12'h038, 32'h040);
      evt_pulse(11'h3C0);
      apb_rd(12'h03C, r);
      check("R9 raw from events", r, 32'h3C0);
      apb_rd(12'h040, r);
      check("R10 masked subset", r, 32'h040);
      check("R12 irq from event", 32'(irq_o), 32'h1);
      apb_wr(12'h038, 32'h0);
      check("R12 irq masked off", 32'(irq_o), 32'h0);

      // R11 set beats clear in the same cycle
      apb_wr(12'h044, 32'h7FF);
      apb_wr_evt(12'h044, 32'h2, 11'h002);
      apb_rd(12'h03C, r);
      check("R11 set wins over clear", r, 32'h2);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule